// File: doc/BRIEF.md
# Fuzzy Similarity Scoring Engine

This block scores how well one left-image pixel matches one right-image candidate at a single disparity level. Three 8-bit similarity measures arrive together: a window matching cost and two edge-distance similarities, one taken toward the left and one toward the right. Each measure is graded into three fuzzy degrees (good, medium, bad) by piecewise-linear membership functions. The multiplications and divisions in these functions reduce to shifts, because every slope is a power of two.

Eighteen rules pair the cost grade with one of the two edge grades. Each rule's strength is the smaller of its two degrees. That strength is mapped through a short linear consequent equation that uses only shifts, adds and subtracts. The score is the mean of the two largest consequents. A disparity tag travels alongside each input set, so a downstream stage can pick the best level. The engine accepts a new input set on every clock.

Top module: `fz_sim_engine`

## Requirements
- R1: While rst_ni is low, and after it is released with no input, valid_o, tag_o and sim_o are all 0.
- R2: A set accepted with valid_i high at a rising edge comes out with valid_o high, and with its own tag on tag_o, exactly three rising edges later, counting the accepting edge as the first. valid_o is low in every other cycle.
- R3: The good degree of an input h is 255−h. The bad degree is h.
- R4: The medium degree is 2h when h<128, and 2(255−h) when h≥128.
- R5: Each rule's strength is min(cost degree, edge degree). The nine left-edge rules use cost set × edge_l_i set. The nine right-edge rules use cost set × edge_r_i set. Each pairing below is written cost/edge.
  - Left-edge rules: good/good and good/medium give good; medium/medium and bad/bad give bad; the other five give medium.
  - Right-edge rules: good/good gives good; medium/good, bad/medium and bad/bad give bad; the other five give medium.
- R6: A good-output rule yields its strength e. A bad-output rule yields 255−e.
- R7: A medium-output rule yields (1280−e)/8 (floor) when cost_i≥128. Otherwise it yields (e−768)/8. The result is clamped to the range 0..255, so it is 0 whenever cost_i<128.
- R8: sim_o is floor((m1+m2)/2), where m1 and m2 are the two largest of the 18 consequents. A value that occurs more than once counts once for each occurrence.
- R9: In a cycle where valid_o is low, sim_o and tag_o keep their previous values.
- R10: Input sets presented on consecutive clocks, with or without idle gaps between them, each produce exactly one result, in the order they were presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input set present this cycle |
| tag_i | input | TAG_W | Disparity tag carried with the set |
| cost_i | input | DW | Window matching cost similarity |
| edge_l_i | input | DW | Left edge-distance similarity |
| edge_r_i | input | DW | Right edge-distance similarity |
| valid_o | output | 1 | Result present this cycle |
| tag_o | output | TAG_W | Tag of the result |
| sim_o | output | DW | Fuzzy similarity score |

## Verification
Every result appears after the third rising edge that follows its acceptance. One register stage holds the degrees, one holds the consequents, and one holds the score. The bench therefore drives inputs on falling edges and compares outputs on falling edges. Expected scores and tags wait in a queue and are popped only when valid_o is high, so each result is matched against the set presented three edges earlier. The isolated-input tests also confirm that valid_o stays low after the first and second edges. In idle cycles the bench checks that the outputs did not move since the last result.

// File: rtl/fz_pkg.sv
package fz_pkg;

  localparam int unsigned N_SETS    = 3;
  localparam int unsigned N_SIDE    = 9;
  localparam int unsigned N_RULES   = 2 * N_SIDE;

  typedef enum logic [1:0] {
    SET_GOOD = 2'd0,
    SET_MED  = 2'd1,
    SET_BAD  = 2'd2
  } fz_set_e;

  typedef enum logic [1:0] {
    OUT_GOOD = 2'd0,
    OUT_MED  = 2'd1,
    OUT_BAD  = 2'd2
  } fz_out_e;

  // side 0 pairs cost with left edge, side 1 with right edge
  function automatic fz_out_e rule_out(input int side, input int cs, input int ds);
    fz_out_e o;
    o = OUT_MED;
    if (side == 0) begin
      if (cs == 0 && (ds == 0 || ds == 1)) o = OUT_GOOD;
      if (cs == ds && cs != 0)             o = OUT_BAD;
    end else begin
      if (cs == 0 && ds == 0)              o = OUT_GOOD;
      if ((cs == 1 && ds == 0) || (cs == 2 && ds != 0)) o = OUT_BAD;
    end
    return o;
  endfunction

endpackage

// File: rtl/fz_fuzzify.sv
module fz_fuzzify #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0]         h_i,
  output logic [2:0][DW-1:0]    mu_o
);
  logic [DW-2:0] fold;

  // slopes are 1 and 2, so every degree is a bit manipulation
  always_comb begin
    fold     = h_i[DW-1] ? ~h_i[DW-2:0] : h_i[DW-2:0];
    mu_o[0]  = ~h_i;
    mu_o[1]  = {fold, 1'b0};
    mu_o[2]  = h_i;
  end
endmodule

// File: rtl/fz_rule_bank.sv
module fz_rule_bank
  import fz_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [2:0][DW-1:0]         mu_c_i,
  input  logic [2:0][DW-1:0]         mu_l_i,
  input  logic [2:0][DW-1:0]         mu_r_i,
  input  logic                       gov_hi_i,
  output logic [N_RULES-1:0][DW-1:0] cq_o
);
  localparam int unsigned SW = DW + 4;
  localparam logic signed [SW-1:0] LO_K = SW'(3 << DW);
  localparam logic signed [SW-1:0] HI_K = SW'(5 << DW);
  localparam logic signed [SW-1:0] MAXS = SW'((1 << DW) - 1);

  for (genvar r = 0; r < N_RULES; r++) begin : g_rule
    localparam int SIDE = r / N_SIDE;
    localparam int CS   = (r % N_SIDE) / N_SETS;
    localparam int DS   = r % N_SETS;
    localparam fz_out_e OC = rule_out(SIDE, CS, DS);

    logic [DW-1:0] ed, ante;
    assign ed   = (SIDE == 0) ? mu_l_i[DS] : mu_r_i[DS];
    assign ante = (mu_c_i[CS] < ed) ? mu_c_i[CS] : ed;

    if (OC == OUT_GOOD) begin : g_good
      assign cq_o[r] = ante;
    end else if (OC == OUT_BAD) begin : g_bad
      assign cq_o[r] = ~ante;
    end else begin : g_med
      logic signed [SW-1:0] ext, f3v;
      always_comb begin
        ext = $signed({{(SW-DW){1'b0}}, ante});
        f3v = gov_hi_i ? ((HI_K - ext) >>> 3) : ((ext - LO_K) >>> 3);
        if (f3v < 0)         cq_o[r] = '0;
        else if (f3v > MAXS) cq_o[r] = '1;
        else                 cq_o[r] = f3v[DW-1:0];
      end
    end
  end
endmodule

// File: rtl/fz_top2_mean.sv
module fz_top2_mean #(
  parameter int unsigned DW = 8,
  parameter int unsigned N  = 18
) (
  input  logic [N-1:0][DW-1:0] v_i,
  output logic [DW-1:0]        mean_o
);
  logic [DW-1:0] m1, m2;
  logic [DW:0]   sum;

  always_comb begin
    m1 = '0;
    m2 = '0;
    for (int i = 0; i < N; i++) begin
      if (v_i[i] > m1) begin
        m2 = m1;
        m1 = v_i[i];
      end else if (v_i[i] > m2) begin
        m2 = v_i[i];
      end
    end
    sum    = {1'b0, m1} + {1'b0, m2};
    mean_o = sum[DW:1];
  end
endmodule

// File: rtl/fz_sim_engine.sv
module fz_sim_engine
  import fz_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned TAG_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [DW-1:0]    cost_i,
  input  logic [DW-1:0]    edge_l_i,
  input  logic [DW-1:0]    edge_r_i,
  output logic             valid_o,
  output logic [TAG_W-1:0] tag_o,
  output logic [DW-1:0]    sim_o
);
  localparam int unsigned N_PAR = 3;

  logic [N_PAR-1:0][DW-1:0]      par;
  logic [N_PAR-1:0][2:0][DW-1:0] mu_d, mu_q;
  logic                          gov_q;
  logic                          v1_q, v2_q;
  logic [TAG_W-1:0]              tag1_q, tag2_q;
  logic [N_RULES-1:0][DW-1:0]    cq_d, cq_q;
  logic [DW-1:0]                 mean_d;

  assign par = {edge_r_i, edge_l_i, cost_i};

  for (genvar p = 0; p < N_PAR; p++) begin : g_fz
    fz_fuzzify #(.DW(DW)) u_fz (
      .h_i  (par[p]),
      .mu_o (mu_d[p])
    );
  end

  // stage 1: degrees
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q   <= 1'b0;
      mu_q   <= '0;
      gov_q  <= 1'b0;
      tag1_q <= '0;
    end else begin
      v1_q <= valid_i;
      if (valid_i) begin
        mu_q   <= mu_d;
        gov_q  <= cost_i[DW-1];
        tag1_q <= tag_i;
      end
    end
  end

  fz_rule_bank #(.DW(DW)) u_rules (
    .mu_c_i   (mu_q[0]),
    .mu_l_i   (mu_q[1]),
    .mu_r_i   (mu_q[2]),
    .gov_hi_i (gov_q),
    .cq_o     (cq_d)
  );

  // stage 2: consequents
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v2_q   <= 1'b0;
      cq_q   <= '0;
      tag2_q <= '0;
    end else begin
      v2_q <= v1_q;
      if (v1_q) begin
        cq_q   <= cq_d;
        tag2_q <= tag1_q;
      end
    end
  end

  fz_top2_mean #(.DW(DW), .N(N_RULES)) u_mean (
    .v_i    (cq_q),
    .mean_o (mean_d)
  );

  // stage 3: score
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sim_o   <= '0;
      tag_o   <= '0;
    end else begin
      valid_o <= v2_q;
      if (v2_q) begin
        sim_o <= mean_d;
        tag_o <= tag2_q;
      end
    end
  end
endmodule

// File: rtl/fz_sim_engine_chk.sv
module fz_sim_engine_chk #(
  parameter int unsigned DW    = 8,
  parameter int unsigned TAG_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [TAG_W-1:0] tag_i,
  input logic [DW-1:0]    cost_i,
  input logic [DW-1:0]    edge_l_i,
  input logic [DW-1:0]    edge_r_i,
  input logic             valid_o,
  input logic [TAG_W-1:0] tag_o,
  input logic [DW-1:0]    sim_o
);
  logic [2:0]            v_sh, zero_sh, max_sh;
  logic [2:0][TAG_W-1:0] tag_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_sh    <= '0;
      zero_sh <= '0;
      max_sh  <= '0;
      tag_sh  <= '0;
    end else begin
      v_sh    <= {v_sh[1:0], valid_i};
      zero_sh <= {zero_sh[1:0], valid_i && cost_i == '0 && edge_l_i == '0 && edge_r_i == '0};
      max_sh  <= {max_sh[1:0], valid_i && (&cost_i) && (&edge_l_i) && (&edge_r_i)};
      tag_sh  <= {tag_sh[1:0], tag_i};
    end
  end

  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == v_sh[2]);

  p_tag_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> tag_o == tag_sh[2]);

  p_hold_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(sim_o) && $stable(tag_o)));

  p_all_zero_top_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && zero_sh[2]) |-> sim_o == {DW{1'b1}});

  p_all_max_f2_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && max_sh[2]) |-> sim_o == {DW{1'b1}});
endmodule

bind fz_sim_engine fz_sim_engine_chk #(.DW(DW), .TAG_W(TAG_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .tag_i    (tag_i),
  .cost_i   (cost_i),
  .edge_l_i (edge_l_i),
  .edge_r_i (edge_r_i),
  .valid_o  (valid_o),
  .tag_o    (tag_o),
  .sim_o    (sim_o)
);

// File: tb/fz_sim_engine_bench.sv
module fz_sim_engine_bench;
  localparam int DW = 8;
  localparam int TAG_W = 4;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             valid_i = 1'b0;
  logic [TAG_W-1:0] tag_i = '0;
  logic [DW-1:0]    cost_i = '0, edge_l_i = '0, edge_r_i = '0;
  logic             valid_o;
  logic [TAG_W-1:0] tag_o;
  logic [DW-1:0]    sim_o;

  int checks = 0;
  int errors = 0;
  bit mon_en = 1'b0;
  int last_sim = 0;
  int last_tag = 0;
  int exp_q[$];
  int tag_q[$];
  int e_sim, e_tag;

  always #10 clk_i = ~clk_i;

  fz_sim_engine #(.DW(DW), .TAG_W(TAG_W)) u_fz_sim_engine (
    .clk_i, .rst_ni, .valid_i, .tag_i, .cost_i, .edge_l_i, .edge_r_i,
    .valid_o, .tag_o, .sim_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // degree per set: 0 good, 1 medium, 2 bad
  function automatic int mu(input int h, input int s);
    if (s == 0) return 255 - h;
    if (s == 2) return h;
    return (h < 128) ? 2 * h : 2 * (255 - h);
  endfunction

  // 0 good, 1 medium, 2 bad output class
  function automatic int rclass(input int side, input int cs, input int ds);
    if (side == 0) begin
      if (cs == 0 && ds <= 1) return 0;
      if ((cs == 1 && ds == 1) || (cs == 2 && ds == 2)) return 2;
      return 1;
    end
    if (cs == 0 && ds == 0) return 0;
    if ((cs == 1 && ds == 0) || (cs == 2 && ds == 1) || (cs == 2 && ds == 2)) return 2;
    return 1;
  endfunction

  function automatic int model(input int c, input int l, input int r);
    int b1 = 0, b2 = 0;
    for (int side = 0; side < 2; side++)
      for (int cs = 0; cs < 3; cs++)
        for (int ds = 0; ds < 3; ds++) begin
          int a = mu(c, cs);
          int d = mu(side == 0 ? l : r, ds);
          int e = (a < d) ? a : d;
          int q;
          case (rclass(side, cs, ds))
            0: q = e;
            2: q = 255 - e;
            default: begin
              q = (c >= 128) ? (1280 - e) / 8 : (e - 768) / 8;
              if (q < 0) q = 0;
              if (q > 255) q = 255;
            end
          endcase
          if (q > b1) begin b2 = b1; b1 = q; end
          else if (q > b2) b2 = q;
        end
    return (b1 + b2) / 2;
  endfunction

  // isolated set: checks R2 timing, the score under req, then R9 hold
  task automatic single(input int c, input int l, input int r, input int t, input string req);
    int ex;
    ex = model(c, l, r);
    @(negedge clk_i);
    valid_i = 1'b1; tag_i = TAG_W'(t);
    cost_i = DW'(c); edge_l_i = DW'(l); edge_r_i = DW'(r);
    @(negedge clk_i);
    valid_i = 1'b0;
    chk(valid_o == 1'b0, "R2 early1", int'(valid_o), 0);
    @(negedge clk_i);
    chk(valid_o == 1'b0, "R2 early2", int'(valid_o), 0);
    @(negedge clk_i);
    chk(valid_o == 1'b1, "R2 due", int'(valid_o), 1);
    chk(int'(tag_o) == t, "R2 tag", int'(tag_o), t);
    chk(int'(sim_o) == ex, req, int'(sim_o), ex);
    cost_i = ~cost_i; edge_l_i = ~edge_l_i;
    @(negedge clk_i);
    chk(valid_o == 1'b0, "R2 after", int'(valid_o), 0);
    chk(int'(sim_o) == ex, "R9 hold", int'(sim_o), ex);
  endtask

  always @(negedge clk_i) begin
    if (mon_en) begin
      if (valid_o) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10 extra result", int'(sim_o), -1);
        end else begin
          e_sim = exp_q.pop_front();
          e_tag = tag_q.pop_front();
          chk(int'(sim_o) == e_sim, "R8 stream", int'(sim_o), e_sim);
          chk(int'(tag_o) == e_tag, "R10 order", int'(tag_o), e_tag);
        end
        last_sim = int'(sim_o);
        last_tag = int'(tag_o);
      end else begin
        chk(int'(sim_o) == last_sim && int'(tag_o) == last_tag, "R9 idle",
            int'(sim_o), last_sim);
      end
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(valid_o == 1'b0, "R1 valid", int'(valid_o), 0);
    chk(sim_o == '0, "R1 sim", int'(sim_o), 0);
    chk(tag_o == '0, "R1 tag", int'(tag_o), 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk(valid_o == 1'b0 && sim_o == '0, "R1 idle", int'(sim_o), 0);

    single(0, 0, 0, 1, "R8 all zero");
    single(0, 100, 0, 2, "R3 good cost");
    single(255, 255, 255, 3, "R6 all max");
    single(64, 192, 32, 4, "R4 medium rising");
    single(200, 128, 160, 5, "R4 medium falling");
    single(128, 128, 128, 6, "R5 peak pairing");
    single(40, 230, 230, 7, "R5 bad edges");
    single(127, 60, 200, 8, "R7 cost low");
    single(128, 60, 200, 9, "R7 cost high");
    single(200, 200, 200, 10, "R7 medium clamp");
    single(90, 10, 245, 11, "R3 bad edge");
    single(180, 20, 20, 12, "R6 bad rules");

    // back-to-back sweep with an idle gap after each row
    @(negedge clk_i);
    last_sim = int'(sim_o);
    last_tag = int'(tag_o);
    mon_en = 1'b1;
    for (int c = 0; c < 256; c++) begin
      for (int li = 0; li < 16; li++) begin
        for (int ri = 0; ri < 16; ri++) begin
          int t = (c * 256 + li * 16 + ri) % 16;
          valid_i = 1'b1;
          tag_i = TAG_W'(t);
          cost_i = DW'(c); edge_l_i = DW'(li * 17); edge_r_i = DW'(ri * 17);
          exp_q.push_back(model(c, li * 17, ri * 17));
          tag_q.push_back(t);
          @(negedge clk_i);
        end
        valid_i = 1'b0;
        cost_i = '1;
        @(negedge clk_i);
      end
    end
    valid_i = 1'b0;
    repeat (5) @(negedge clk_i);
    mon_en = 1'b0;
    chk(exp_q.size() == 0, "R10 all drained", exp_q.size(), 0);
    finish_run();
  end
endmodule